// File: doc/BRIEF.md
# Programmable Watchdog Countdown Timer

This block is a watchdog countdown timer run through two 8-bit registers on a plain register bus with a write strobe. One register holds the mode and enable bits. The other is the counter register.

Writing a non-zero value to the counter register loads that value and starts a countdown. Each decrement takes one tick. A tick lasts one second or one minute, and a mode bit can make it 1000 times shorter. When the count reaches zero the block sets a sticky timeout flag. If enabled, it also drives a fixed-length low pulse on an active-low reset output.

Keyboard or mouse interrupt activity can re-arm the count with the last non-zero value written. A rising edge on a keyboard-controller reset input can force a timeout at once. Reads of the counter register return the live count.

Top module: `wdog_timer`

## Requirements
- R1: After reset the mode register reads 00h and the counter register reads 04h. The flag is clear and `kbRstN` is high. The count stays at 04h until the counter register is written or a reload event occurs.
- R2: A write with `regSel`=1 loads `wrData` into the down-counter. A non-zero value starts counting. Reading with `regSel`=1 returns the live count.
- R3: Mode bit 3 selects minute ticks (SEC_CYCLES*MIN_FACTOR clocks) when 1 and second ticks (SEC_CYCLES clocks) when 0. Mode bit 4 set divides the tick length by FAST_FACTOR. A value N expires exactly N ticks after the write.
- R4: When the count reaches zero, `timedOut` sets in the same clock edge. Counting then stops and the count stays at zero.
- R5: Any write to the counter register clears `timedOut`. Writing 00h stops the countdown without a timeout.
- R6: Mode bit 7 enables keyboard reload and mode bit 6 enables mouse reload. Each clock with `kbdIrq` or `mouseIrq` high and its bit set reloads the last non-zero value written (04h after reset) and restarts the tick. An interrupt whose bit is clear has no effect.
- R7: With mode bit 1 set, each timeout drives `kbRstN` low for PULSE_LEN clocks, starting at the edge that sets the flag. With bit 1 clear, `kbRstN` stays high.
- R8: With mode bit 2 set, a rising edge on `kbcRstIn` forces a timeout. The count goes to zero, the flag sets and a pulse fires. Holding the input high gives no further event. With bit 2 clear, the edge has no effect.
- R9: Mode bits 5 and 0 are reserved and always read as zero.
- R10: A counter-register write takes priority over a reload or forced timeout in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the mode register, 1 selects the counter register |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected register |
| kbdIrq | input | 1 | Keyboard interrupt activity |
| mouseIrq | input | 1 | Mouse interrupt activity |
| kbcRstIn | input | 1 | Keyboard-controller reset request (rising edge) |
| timedOut | output | 1 | Sticky timeout flag |
| kbRstN | output | 1 | Active-low reset pulse output |

## Verification
The assertions check the per-clock rules on every cycle. These are: loading on a counter write, decrements of at most one between events, a zero count holding, the flag clearing on writes, the pulse never starting without the flag, the forced timeout on an enabled edge, and the reserved read bits. Only the bench scenarios can show the exact expiry time in each of the four tick modes and the exact pulse length. They also cover the choice between ignored and enabled interrupt reloads, and same-cycle priority. A behavioural reference model compared every clock shows these.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef struct packed {
    logic kbdReload;
    logic mouseReload;
    logic rsvHi;
    logic fastRate;
    logic minuteUnit;
    logic kbcForceEn;
    logic pulseEn;
    logic rsvLo;
  } wdCtrl_t;

  typedef struct packed {
    logic       load;
    logic       expireNow;
    logic       reload;
    logic [7:0] value;
  } wdStrobe_t;

  localparam logic [7:0] CTRL_WR_MASK = 8'hDE;
  localparam logic [7:0] CNT_RESET    = 8'h04;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       regSel,
  input  logic [7:0] wrData,
  input  logic       kbdIrq,
  input  logic       mouseIrq,
  input  logic       kbcRstIn,
  input  logic [7:0] cntVal,
  output wdCtrl_t    ctrlQ,
  output wdStrobe_t  strb,
  output logic [7:0] rdData
);
  logic [7:0] reloadQ;
  logic       kbcPrevQ;
  logic       cntWr;
  logic       ctrlWr;
  logic       kbcRise;

  assign cntWr   = wrEn & regSel;
  assign ctrlWr  = wrEn & ~regSel;
  assign kbcRise = kbcRstIn & ~kbcPrevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      reloadQ  <= CNT_RESET;
      kbcPrevQ <= 1'b0;
    end else begin
      kbcPrevQ <= kbcRstIn;
      if (ctrlWr) ctrlQ <= wdCtrl_t'(wrData & CTRL_WR_MASK);
      if (cntWr && (wrData != 8'h00)) reloadQ <= wrData;
    end
  end

  always_comb begin
    strb.load      = cntWr;
    strb.expireNow = ctrlQ.kbcForceEn & kbcRise;
    strb.reload    = (kbdIrq & ctrlQ.kbdReload) | (mouseIrq & ctrlQ.mouseReload);
    strb.value     = cntWr ? wrData : reloadQ;
    rdData         = regSel ? cntVal : ctrlQ;
  end
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int unsigned SEC_CYCLES  = 50_300_000,
  parameter int unsigned MIN_FACTOR  = 60,
  parameter int unsigned FAST_FACTOR = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  wdStrobe_t  strb,
  input  logic       fastRate,
  input  logic       minuteUnit,
  output logic [7:0] cntQ,
  output logic       fire,
  output logic       timedOut
);
  localparam longint unsigned MIN_CYCLES  = longint'(SEC_CYCLES) * longint'(MIN_FACTOR);
  localparam longint unsigned FSEC_CYCLES = longint'(SEC_CYCLES) / longint'(FAST_FACTOR);
  localparam longint unsigned FMIN_CYCLES = MIN_CYCLES / longint'(FAST_FACTOR);
  localparam int PRE_W = (MIN_CYCLES > 2) ? $clog2(MIN_CYCLES) : 1;
  localparam logic [PRE_W-1:0] LAST_SEC  = PRE_W'(longint'(SEC_CYCLES) - 1);
  localparam logic [PRE_W-1:0] LAST_MIN  = PRE_W'(MIN_CYCLES - 1);
  localparam logic [PRE_W-1:0] LAST_FSEC = PRE_W'(FSEC_CYCLES - 1);
  localparam logic [PRE_W-1:0] LAST_FMIN = PRE_W'(FMIN_CYCLES - 1);

  logic [PRE_W-1:0] preQ;
  logic [PRE_W-1:0] lastTick;
  logic             armedQ;
  logic             tickDue;

  always_comb begin
    unique case ({fastRate, minuteUnit})
      2'b00:   lastTick = LAST_SEC;
      2'b01:   lastTick = LAST_MIN;
      2'b10:   lastTick = LAST_FSEC;
      default: lastTick = LAST_FMIN;
    endcase
  end

  assign tickDue = armedQ && (preQ >= lastTick);
  assign fire    = !strb.load &&
                   (strb.expireNow || (!strb.reload && tickDue && (cntQ == 8'd1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= CNT_RESET;
      armedQ <= 1'b0;
      preQ   <= '0;
    end else if (strb.load) begin
      cntQ   <= strb.value;
      armedQ <= (strb.value != 8'h00);
      preQ   <= '0;
    end else if (strb.expireNow) begin
      cntQ   <= 8'h00;
      armedQ <= 1'b0;
      preQ   <= '0;
    end else if (strb.reload) begin
      cntQ   <= strb.value;
      armedQ <= 1'b1;
      preQ   <= '0;
    end else if (armedQ) begin
      if (tickDue) begin
        preQ <= '0;
        cntQ <= cntQ - 8'd1;
        if (cntQ == 8'd1) armedQ <= 1'b0;
      end else begin
        preQ <= preQ + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          timedOut <= 1'b0;
    else if (strb.load) timedOut <= 1'b0;
    else if (fire)      timedOut <= 1'b1;
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic fire,
  input  logic pulseEn,
  output logic kbRstN
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  logic [PW-1:0] remainQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 remainQ <= '0;
    else if (fire && pulseEn)  remainQ <= PW'(PULSE_LEN);
    else if (remainQ != '0)    remainQ <= remainQ - PW'(1);
  end

  assign kbRstN = (remainQ == '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned SEC_CYCLES  = 50_300_000,
  parameter int unsigned MIN_FACTOR  = 60,
  parameter int unsigned FAST_FACTOR = 1000,
  parameter int unsigned PULSE_LEN   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       regSel,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       kbdIrq,
  input  logic       mouseIrq,
  input  logic       kbcRstIn,
  output logic       timedOut,
  output logic       kbRstN
);
  wdCtrl_t    ctrlQ;
  wdStrobe_t  strb;
  logic [7:0] cntQ;
  logic       fire;

  wdog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .kbdIrq(kbdIrq), .mouseIrq(mouseIrq), .kbcRstIn(kbcRstIn), .cntVal(cntQ),
    .ctrlQ(ctrlQ), .strb(strb), .rdData(rdData)
  );

  wdog_datapath #(
    .SEC_CYCLES(SEC_CYCLES), .MIN_FACTOR(MIN_FACTOR), .FAST_FACTOR(FAST_FACTOR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fastRate(ctrlQ.fastRate),
    .minuteUnit(ctrlQ.minuteUnit), .cntQ(cntQ), .fire(fire), .timedOut(timedOut)
  );

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rstN(rstN), .fire(fire), .pulseEn(ctrlQ.pulseEn), .kbRstN(kbRstN)
  );
endmodule

// File: rtl/wdog_checks.sv
module wdog_checks
  import wdog_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       regSel,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       kbdIrq,
  input logic       mouseIrq,
  input logic       kbcRstIn,
  input logic       timedOut,
  input logic       kbRstN,
  input logic [7:0] cntQ,
  input wdCtrl_t    ctrlQ
);
  logic kbcSeenQ;
  logic cntWr;
  logic quiet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) kbcSeenQ <= 1'b0;
    else       kbcSeenQ <= kbcRstIn;
  end

  assign cntWr = wrEn && regSel;
  assign quiet = !cntWr && !kbdIrq && !mouseIrq && !kbcRstIn;

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> cntQ == $past(wrData)); // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    quiet |=> (cntQ == $past(cntQ)) || (cntQ == $past(cntQ) - 8'd1)); // R3
  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == 8'h00 && quiet) |=> cntQ == 8'h00); // R4
  AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> !timedOut); // R5
  AST_RELOAD_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (kbdIrq && ctrlQ.kbdReload && !cntWr && !(kbcRstIn && !kbcSeenQ && ctrlQ.kbcForceEn))
      |=> cntQ != 8'h00); // R6
  AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $fell(kbRstN) |-> timedOut); // R7
  AST_NO_PULSE_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ.pulseEn && kbRstN) |=> kbRstN); // R7
  AST_KBC_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    (kbcRstIn && !kbcSeenQ && ctrlQ.kbcForceEn && !cntWr) |=> (cntQ == 8'h00) && timedOut); // R8
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !regSel |-> (rdData[5] == 1'b0) && (rdData[0] == 1'b0)); // R9
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (cntWr && kbcRstIn && !kbcSeenQ) |=> !timedOut && cntQ == $past(wrData)); // R10
endmodule

bind wdog_timer wdog_checks u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
  .rdData(rdData), .kbdIrq(kbdIrq), .mouseIrq(mouseIrq), .kbcRstIn(kbcRstIn),
  .timedOut(timedOut), .kbRstN(kbRstN), .cntQ(cntQ), .ctrlQ(ctrlQ)
);

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  localparam int CLK_PERIOD = 10;
  localparam int SEC  = 40;
  localparam int MINF = 3;
  localparam int FAST = 10;
  localparam int PL   = 5;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, regSel = 1'b1, kbdIrq = 1'b0, mouseIrq = 1'b0, kbcRstIn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic timedOut, kbRstN;

  int nChecks = 0, nErr = 0, cycles = 0;
  int mCtrl, mCnt, mRel, mArmed, mPre, mFlag, mPulse, mKbcPrev;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer #(.SEC_CYCLES(SEC), .MIN_FACTOR(MINF), .FAST_FACTOR(FAST), .PULSE_LEN(PL)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData), .rdData(rdData),
    .kbdIrq(kbdIrq), .mouseIrq(mouseIrq), .kbcRstIn(kbcRstIn), .timedOut(timedOut), .kbRstN(kbRstN)
  );

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int tickLen(int c);
    int len;
    len = c[3] ? SEC * MINF : SEC;
    if (c[4]) len = len / FAST;
    return len;
  endfunction

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    int len, fire, edgeSeen, reloadHit;
    if (!rstN) begin
      mCtrl = 0; mCnt = 4; mRel = 4; mArmed = 0; mPre = 0; mFlag = 0; mPulse = 0; mKbcPrev = 0;
    end else begin
      len = tickLen(mCtrl);
      fire = 0;
      edgeSeen = (kbcRstIn && !mKbcPrev) ? 1 : 0;
      mKbcPrev = kbcRstIn;
      reloadHit = ((kbdIrq && mCtrl[7]) || (mouseIrq && mCtrl[6])) ? 1 : 0;
      if (wrEn && regSel) begin
        mCnt = wrData; mArmed = (wrData != 0); mPre = 0; mFlag = 0;
        if (wrData != 0) mRel = wrData;
      end else if (edgeSeen != 0 && mCtrl[2]) begin
        mCnt = 0; mArmed = 0; mPre = 0; fire = 1;
      end else if (reloadHit != 0) begin
        mCnt = mRel; mArmed = 1; mPre = 0;
      end else if (mArmed != 0) begin
        if (mPre + 1 >= len) begin
          mPre = 0; mCnt--;
          if (mCnt == 0) begin mArmed = 0; fire = 1; end
        end else mPre++;
      end
      if (fire != 0 && mCtrl[1]) mPulse = PL;
      else if (mPulse > 0) mPulse--;
      if (fire != 0) mFlag = 1;
      if (wrEn && !regSel) mCtrl = wrData & 8'hDE;
    end
    #1;
    if (rstN) begin
      chk(regSel ? "R2 live count vs model" : "R9 mode read vs model",
          rdData, regSel ? mCnt : mCtrl);
      chk("R4 flag vs model", timedOut, mFlag);
      chk("R7 pulse vs model", kbRstN, (mPulse == 0) ? 1 : 0);
    end
    cycles++;
    if (cycles > WATCHDOG) begin
      nErr++;
      $display("FAIL watchdog: actual=%0d cycles expected below %0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks + 1);
      $finish;
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    wrEn = 1'b1; regSel = sel; wrData = d;
    cyc();
    wrEn = 1'b0; regSel = 1'b1;
  endtask

  task automatic rdCtrl(output int v);
    regSel = 1'b0; #1; v = rdData; regSel = 1'b1; #1;
  endtask

  task automatic waitFlag(int maxc, output int k);
    k = 0;
    while (!timedOut && k < maxc) begin cyc(); k++; end
  endtask

  task automatic countLow(int win, output int n);
    n = (kbRstN == 1'b0) ? 1 : 0;
    for (int i = 0; i < win; i++) begin
      cyc();
      if (kbRstN == 1'b0) n++;
    end
  endtask

  initial begin
    int v, k, n;
    cyc(3);
    rstN = 1'b1;
    cyc();
    rdCtrl(v);
    chk("R1 mode reset", v, 0);
    chk("R1 count reset", rdData, 4);
    chk("R1 flag reset", timedOut, 0);
    chk("R1 kbRstN reset", kbRstN, 1);
    cyc(200);
    chk("R1 count idle after reset", rdData, 4);

    // second ticks, pulse enabled
    wr(1'b0, 8'h02);
    wr(1'b1, 8'd3);
    chk("R2 load", rdData, 3);
    waitFlag(400, k);
    chk("R3 second mode expiry", k, 3 * SEC);
    chk("R7 pulse starts with flag", kbRstN, 0);
    countLow(20, n);
    chk("R7 pulse length", n, PL);
    chk("R4 count stays zero", rdData, 0);
    chk("R4 flag sticky", timedOut, 1);

    // fast second, fast minute, minute
    wr(1'b0, 8'h10);
    wr(1'b1, 8'd5);
    chk("R5 write clears flag", timedOut, 0);
    waitFlag(400, k);
    chk("R3 fast second expiry", k, 5 * SEC / FAST);
    wr(1'b0, 8'h18);
    wr(1'b1, 8'd2);
    waitFlag(400, k);
    chk("R3 fast minute expiry", k, 2 * SEC * MINF / FAST);
    wr(1'b0, 8'h08);
    wr(1'b1, 8'd1);
    waitFlag(400, k);
    chk("R3 minute expiry", k, SEC * MINF);
    chk("R7 no pulse when disabled", kbRstN, 1);

    // write zero stops countdown
    wr(1'b0, 8'h02);
    wr(1'b1, 8'd6);
    cyc(50);
    wr(1'b1, 8'd0);
    chk("R5 zero write count", rdData, 0);
    chk("R5 zero write flag", timedOut, 0);
    cyc(300);
    chk("R5 no timeout after stop", timedOut, 0);
    chk("R5 no pulse after stop", kbRstN, 1);

    // interrupt reloads
    wr(1'b0, 8'h80);
    wr(1'b1, 8'd2);
    cyc(60);
    chk("R2 live count mid run", rdData, 1);
    kbdIrq = 1'b1; cyc(); kbdIrq = 1'b0;
    chk("R6 keyboard reload", rdData, 2);
    mouseIrq = 1'b1; cyc(); mouseIrq = 1'b0;
    chk("R6 mouse ignored count", rdData, 2);
    waitFlag(400, k);
    chk("R6 mouse ignored expiry", k, 2 * SEC - 1);
    wr(1'b0, 8'h40);
    mouseIrq = 1'b1; cyc(); mouseIrq = 1'b0;
    chk("R6 mouse reload after expiry", rdData, 2);
    chk("R6 flag stays after reload", timedOut, 1);

    // forced timeout from controller reset edge
    wr(1'b0, 8'h06);
    wr(1'b1, 8'd9);
    cyc(3);
    kbcRstIn = 1'b1; cyc();
    chk("R8 forced count", rdData, 0);
    chk("R8 forced flag", timedOut, 1);
    chk("R8 forced pulse", kbRstN, 0);
    countLow(12, n);
    chk("R8 single pulse while held", n, PL);
    kbcRstIn = 1'b0;
    wr(1'b0, 8'h02);
    wr(1'b1, 8'd9);
    kbcRstIn = 1'b1; cyc();
    chk("R8 edge ignored flag", timedOut, 0);
    chk("R8 edge ignored count", rdData, 9);
    kbcRstIn = 1'b0;

    // reserved bits
    wr(1'b0, 8'hFF);
    rdCtrl(v);
    chk("R9 reserved read zero", v, 8'hDE);

    // priority of counter write
    cyc();
    wrEn = 1'b1; regSel = 1'b1; wrData = 8'd7; kbdIrq = 1'b1; kbcRstIn = 1'b1;
    cyc();
    wrEn = 1'b0; kbdIrq = 1'b0;
    chk("R10 write wins count", rdData, 7);
    chk("R10 write wins flag", timedOut, 0);
    kbcRstIn = 1'b0;
    cyc(2);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule